// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder

This block sits after a UART transmit shifter. It turns the NRZ serial bit into the short infrared pulses that an IrDA SIR link uses. The block advances on a clock enable that ticks sixteen times per bit period. A bit cell that carries a 1 sends no light. A bit cell that carries a 0 sends one pulse near the middle of the cell, at a fixed slot within the sixteen ticks.

Two pulse shapes are available. The short shape lasts three of the sixteen ticks. The fixed shape lasts a number of system clocks taken from a count input, so that software can set an absolute duration such as 1.6 µs whatever the baud rate. In both shapes the pulse starts at the same position in the cell. A 4-bit phase counter tracks the slot. It is held at zero while the line idles high, so each falling edge of the serial input starts a fresh cell.

Top module: `irda_sir_encoder`

## Requirements
- R1: While `tx_bit` is sampled 1, `ir_out` is 0 on the following cycle and the phase counter is 0. A pulse in progress ends one cycle after `tx_bit` rises.
- R2: Ticks are counted from the first tick sampled with `tx_bit` at 0, which is tick 1. `ir_out` rises on the cycle after the edge that samples tick 7 of a cell.
- R3: With `wide_sel` = 0 (short shape), `ir_out` falls on the cycle after the edge that samples tick 10. The pulse is therefore 3 tick periods wide.
- R4: Each run of 16 ticks with `tx_bit` held at 0 produces exactly one pulse. The 4-bit counter wraps from 15 to 0, so back-to-back zero cells pulse at the same slot.
- R5: `wide_sel` is captured when a pulse starts and picks its shape: 0 selects the short shape, 1 selects the fixed shape. Changing `wide_sel` between cells changes the shape of the next pulse.
- R6: With the fixed shape, `ir_out` stays high for exactly `wide_count` clock cycles, where a count of 0 acts as 1.
- R7: A falling edge of `tx_bit` in the middle of a cell realigns the phase. The next pulse starts at tick 7 counted from that new falling edge.
- R8: While `rst` is high, `ir_out` is 0 on the next cycle and the phase counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| tx_bit | input | 1 | NRZ serial data from the UART shifter |
| wide_sel | input | 1 | Pulse shape: 0 = 3/16 of a bit, 1 = fixed clock count |
| wide_count | input | CNT_W | Fixed-shape pulse width in system clocks |
| ir_out | output | 1 | Registered infrared transmit line |

## Verification
On every cycle the assertions check four things. The line and the phase counter are cleared whenever the input is high or reset is held. Every rising edge of the output comes from a start decision. A short pulse never covers more than three ticks, and a fixed pulse never outlasts its latched count. Other behaviours appear only in the bench's scenarios, where exact cycle positions are compared with the expected values. These are the precise start slot, the exact widths, the count of one pulse per zero cell across wraps, the realignment after a mid-cell edge, and the capture of the shape at pulse start.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;
  typedef enum logic {
    PM_SHORT = 1'b0,
    PM_FIXED = 1'b1
  } pulse_mode_e;
endpackage

// File: rtl/irda_phase_ctr.sv
module irda_phase_ctr #(
  parameter int PH_W       = 4,
  parameter int START_SLOT = 6,
  parameter int STOP_SLOT  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            line,
  output logic [PH_W-1:0] phase,
  output logic            start_o,
  output logic            stop_o
);
  localparam logic [PH_W-1:0] START_V = PH_W'(START_SLOT);
  localparam logic [PH_W-1:0] STOP_V  = PH_W'(STOP_SLOT);

  // held at zero while the line idles high; wraps naturally at 2**PH_W
  always_ff @(posedge clk) begin
    if (rst || line) phase <= '0;
    else if (tick)   phase <= phase + 1'b1;
  end

  assign start_o = tick && !line && (phase == START_V);
  assign stop_o  = tick && !line && (phase == STOP_V);
endmodule

// File: rtl/irda_width_timer.sv
module irda_width_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             abort,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] rem;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0;
      rem    <= '0;
    end else if (load) begin
      active <= 1'b1;
      rem    <= (len == '0) ? CNT_W'(1) : len;
    end else if (active) begin
      if (rem == CNT_W'(1)) active <= 1'b0;
      else                  rem    <= rem - 1'b1;
    end
  end

  assign expire = active && (rem == CNT_W'(1));
endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder
  import irda_sir_pkg::*;
#(
  parameter int PH_W       = 4,
  parameter int START_SLOT = 6,
  parameter int STOP_SLOT  = 9,
  parameter int CNT_W      = 8,
  parameter bit HAS_FIXED  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             tx_bit,
  input  logic             wide_sel,
  input  logic [CNT_W-1:0] wide_count,
  output logic             ir_out
);
  logic [PH_W-1:0] phase;
  logic            start;
  logic            stop_short;
  logic            fixed_done;
  pulse_mode_e     mode_q;
  logic            ir_q;

  irda_phase_ctr #(
    .PH_W      (PH_W),
    .START_SLOT(START_SLOT),
    .STOP_SLOT (STOP_SLOT)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .tick   (os_tick),
    .line   (tx_bit),
    .phase  (phase),
    .start_o(start),
    .stop_o (stop_short)
  );

  generate
    if (HAS_FIXED) begin : g_fixed
      irda_width_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (start && wide_sel),
        .abort (tx_bit),
        .len   (wide_count),
        .expire(fixed_done)
      );
    end else begin : g_short_only
      assign fixed_done = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= 1'b0;
      mode_q <= PM_SHORT;
    end else if (tx_bit) begin
      ir_q <= 1'b0;
    end else if (start) begin
      ir_q   <= 1'b1;
      mode_q <= (HAS_FIXED && wide_sel) ? PM_FIXED : PM_SHORT;
    end else if (ir_q && (((mode_q == PM_SHORT) && stop_short) ||
                          ((mode_q == PM_FIXED) && fixed_done))) begin
      ir_q <= 1'b0;
    end
  end

  assign ir_out = ir_q;
endmodule

// File: rtl/irda_sir_encoder_chk.sv
module irda_sir_encoder_chk #(
  parameter int PH_W  = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             os_tick,
  input logic             tx_bit,
  input logic [CNT_W-1:0] wide_count,
  input logic             ir_out,
  input logic             start,
  input logic             mode_fixed,
  input logic [PH_W-1:0]  phase
);
  logic [1:0]       hi_ticks;
  logic [CNT_W:0]   hi_len;
  logic [CNT_W:0]   lat_len;

  always_ff @(posedge clk) begin
    if (rst || start || !ir_out) hi_ticks <= '0;
    else if (os_tick && hi_ticks != 2'd3) hi_ticks <= hi_ticks + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len  <= '0;
      lat_len <= '0;
    end else if (start) begin
      hi_len  <= '0;
      lat_len <= (wide_count == '0) ? (CNT_W+1)'(1) : {1'b0, wide_count};
    end else if (ir_out) begin
      hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    tx_bit |=> (!ir_out && phase == '0));

  a_r2_rise_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_out) |-> $past(start));

  a_r3_short_ticks: assert property (@(posedge clk) disable iff (rst)
    (ir_out && !mode_fixed) |-> (hi_ticks < 2'd3));

  a_r6_fixed_len: assert property (@(posedge clk) disable iff (rst)
    (ir_out && mode_fixed) |-> (hi_len < lat_len));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!ir_out && phase == '0));
endmodule

bind irda_sir_encoder irda_sir_encoder_chk #(.PH_W(PH_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .os_tick   (os_tick),
  .tx_bit    (tx_bit),
  .wide_count(wide_count),
  .ir_out    (ir_out),
  .start     (start),
  .mode_fixed(mode_q == irda_sir_pkg::PM_FIXED),
  .phase     (phase)
);

// File: tb/irda_sir_encoder_tb.sv
module irda_sir_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             os_tick = 1'b0;
  logic             tx_bit = 1'b1;
  logic             wide_sel = 1'b0;
  logic [CNT_W-1:0] wide_count = '0;
  logic             ir_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    rise;
    int    width;
    string rtag;
    string wtag;
  } exp_t;
  exp_t  q[$];
  string cur_tag = "R2";
  int    zc = 0;
  int    pend_end = 0;

  irda_sir_encoder #(.CNT_W(CNT_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .os_tick   (os_tick),
    .tx_bit    (tx_bit),
    .wide_sel  (wide_sel),
    .wide_count(wide_count),
    .ir_out    (ir_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: n tick periods with the line at b; expected pulses go to the queue
  task automatic seg(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (b && !tx_bit && q.size() > 0 && pend_end > cyc + 1) begin
        q[q.size()-1].width = cyc + 1 - q[q.size()-1].rise;
        q[q.size()-1].wtag  = "R1";
        pend_end = cyc + 1;
      end
      if (b) zc = 0;
      else begin
        zc++;
        if (zc % 16 == 7) begin
          exp_t e;
          e.rise  = cyc + 1;
          e.width = wide_sel ? ((wide_count == 0) ? 1 : int'(wide_count)) : 3*TDIV;
          e.rtag  = cur_tag;
          e.wtag  = wide_sel ? "R6" : "R3";
          q.push_back(e);
          pend_end = e.rise + e.width;
        end
      end
      tx_bit  = b;
      os_tick = 1'b1;
      repeat (TDIV-1) begin
        @(negedge clk);
        os_tick = 1'b0;
      end
    end
  endtask

  // monitor: measures each pulse and pops the scoreboard
  logic prev_ir = 1'b0;
  int   rise_c = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ir_out && !prev_ir) rise_c = cyc;
      if (!ir_out && prev_ir) begin
        if (q.size() == 0) begin
          check(1'b0, "R1 unexpected pulse", rise_c, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rise_c == e.rise, e.rtag, rise_c, e.rise);
          check(cyc - rise_c == e.width, e.wtag, cyc - rise_c, e.width);
        end
      end
      prev_ir = ir_out;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ir_out == 1'b0, "R8 reset low", ir_out, 0);
    @(negedge clk);
    tx_bit = 1'b0;
    os_tick = 1'b1;
    repeat (2) @(negedge clk);
    check(ir_out == 1'b0, "R8 reset holds line", ir_out, 0);
    tx_bit = 1'b1;
    os_tick = 1'b0;
    rst = 1'b0;

    cur_tag = "R1";
    seg(1'b1, 32);
    check(ir_out == 1'b0, "R1 idle ones", ir_out, 0);

    cur_tag = "R2";
    seg(1'b0, 16);
    seg(1'b1, 16);

    cur_tag = "R4";
    seg(1'b0, 48);
    seg(1'b1, 16);

    cur_tag = "R5";
    wide_sel = 1'b1;
    wide_count = 8'd20;
    seg(1'b0, 16);
    seg(1'b1, 4);
    wide_sel = 1'b0;
    seg(1'b0, 16);
    seg(1'b1, 16);

    cur_tag = "R6";
    wide_sel = 1'b1;
    wide_count = 8'd5;
    seg(1'b0, 32);
    seg(1'b1, 4);
    wide_count = 8'd0;
    seg(1'b0, 16);
    seg(1'b1, 16);

    cur_tag = "R7";
    wide_sel = 1'b0;
    seg(1'b0, 3);
    seg(1'b1, 2);
    seg(1'b0, 16);
    seg(1'b1, 16);

    cur_tag = "R1";
    wide_sel = 1'b1;
    wide_count = 8'd30;
    seg(1'b0, 8);
    seg(1'b1, 1);
    check(ir_out == 1'b0, "R1 truncated pulse", ir_out, 0);
    seg(1'b1, 16);

    check(q.size() == 0, "R4 all pulses seen", q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule